// File: doc/BRIEF.md
# Four-Stage Pipelined Floating-Point Adder

This block adds two floating-point magnitudes of the same sign. Each operand is an unsigned fraction with the binary point just above its top bit, together with an unsigned base-2 exponent. The work is split into four register-separated stages: the exponents are compared, the fraction with the smaller exponent is aligned, the aligned fractions are added, and the sum is normalized. A new operand pair can enter on every clock. Each result leaves a fixed four cycles later, and a valid flag travels with it.

The normalizer handles both directions. When the fraction add carries out, the sum moves right by one place and the exponent rises by one. Otherwise the sum moves left until its top bit is set, and the exponent drops by the same amount. A zero sum is returned as fraction 0 and exponent 0. Bits shifted off the low end are truncated; the block does not round.

Top module: `fp_add_pipe4`

## Requirements
- R1: A pair taken with `in_valid` high yields its result with `out_valid` high exactly 4 clocks later. Pairs taken on consecutive clocks yield results on consecutive clocks, so n back-to-back pairs finish after 4 + (n - 1) clocks.
- R2: The result exponent before normalization is the larger of the two input exponents. The fraction of the operand with the smaller exponent is shifted right by the exponent difference, with low bits truncated. The sum does not depend on which port carries which operand.
- R3: When the exponent difference is FRAC_W or more, the aligned smaller fraction is zero, so the result equals the larger operand (after normalization).
- R4: When the fraction sum carries out, `out_frac` is the FRAC_W+1-bit sum shifted right by one, dropping its lowest bit, and `out_exp` is the larger exponent plus 1.
- R5: When the sum is nonzero and does not carry out, let u be its number of leading zeros. `out_frac` is the sum shifted left by u, so that bit FRAC_W-1 is set, and `out_exp` is the larger exponent minus u.
- R6: A zero fraction sum gives `out_frac` = 0 and `out_exp` = 0.
- R7: A synchronous `rst` clears every in-flight valid flag, so `out_valid` is low on the clock after reset and no pair taken before the reset ever emerges. A cycle with `in_valid` low produces a cycle with `out_valid` low 4 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present |
| a_frac | input | FRAC_W | Fraction of operand A |
| a_exp | input | EXP_W | Exponent of operand A |
| b_frac | input | FRAC_W | Fraction of operand B |
| b_exp | input | EXP_W | Exponent of operand B |
| out_valid | output | 1 | Result present |
| out_frac | output | FRAC_W | Result fraction |
| out_exp | output | EXP_W | Result exponent |

## Verification
The assertions assume that the exponent stays in range. The larger exponent plus one must not wrap on a carry, and it must be at least the leading-zero count of a nonzero, non-carrying sum. Under those assumptions every nonzero result has its top fraction bit set. The stimulus keeps within these limits by choosing exponents well inside the field whenever a left shift or a carry can occur. Operands whose fractions lack a top bit are used only to reach the left-shift and zero-sum paths.

// File: rtl/fp_add_pipe4.sv
module fp_add_pipe4 #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [FRAC_W-1:0] b_frac,
  input  logic [EXP_W-1:0]  b_exp,
  output logic              out_valid,
  output logic [FRAC_W-1:0] out_frac,
  output logic [EXP_W-1:0]  out_exp
);
  localparam int LZ_W = $clog2(FRAC_W + 1);

  // stage 1: exponent compare
  logic              v1, a_small1;
  logic [EXP_W-1:0]  r1, t1;
  logic [FRAC_W-1:0] fa1, fb1;
  wire a_ge = a_exp >= b_exp;

  always_ff @(posedge clk) begin
    v1       <= rst ? 1'b0 : in_valid;
    r1       <= a_ge ? a_exp : b_exp;
    t1       <= a_ge ? a_exp - b_exp : b_exp - a_exp;
    a_small1 <= !a_ge;
    fa1      <= a_frac;
    fb1      <= b_frac;
  end

  // stage 2: alignment
  logic              v2;
  logic [EXP_W-1:0]  r2;
  logic [FRAC_W-1:0] big2, sml2;
  wire [FRAC_W-1:0] sml_in = a_small1 ? fa1 : fb1;
  wire              gone   = int'(t1) >= FRAC_W;

  always_ff @(posedge clk) begin
    v2   <= rst ? 1'b0 : v1;
    r2   <= r1;
    big2 <= a_small1 ? fb1 : fa1;
    sml2 <= gone ? '0 : sml_in >> t1;
  end

  // stage 3: fraction add with carry bit
  logic              v3;
  logic [EXP_W-1:0]  r3;
  logic [FRAC_W:0]   sum3;

  always_ff @(posedge clk) begin
    v3   <= rst ? 1'b0 : v2;
    r3   <= r2;
    sum3 <= {1'b0, big2} + {1'b0, sml2};
  end

  // stage 4: leading-zero count and normalize
  logic [LZ_W-1:0] lz;
  logic            found;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (sum3[i]) found = 1'b1;
        else         lz    = lz + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    out_valid <= rst ? 1'b0 : v3;
    if (sum3[FRAC_W]) begin
      out_frac <= sum3[FRAC_W:1];
      out_exp  <= r3 + 1'b1;
    end else if (!found) begin
      out_frac <= '0;
      out_exp  <= '0;
    end else begin
      out_frac <= sum3[FRAC_W-1:0] << lz;
      out_exp  <= r3 - EXP_W'(lz);
    end
  end
endmodule

module fp_add_pipe4_chk #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              out_valid,
  input logic [FRAC_W-1:0] out_frac,
  input logic [EXP_W-1:0]  out_exp
);
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                since_rst <= '0;
    else if (since_rst < 4) since_rst <= since_rst + 1'b1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4) |-> (out_valid == $past(in_valid, 4)));

  p_normalized_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_frac != '0) |-> out_frac[FRAC_W-1]);

  p_zero_exp_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_frac == '0) |-> (out_exp == '0));

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind fp_add_pipe4 fp_add_pipe4_chk #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_frac(out_frac), .out_exp(out_exp)
);

// File: tb/fp_add_pipe4_tb_top.sv
module fp_add_pipe4_tb_top;
  localparam int F = 24;
  localparam int E = 8;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [F-1:0] a_frac = '0, b_frac = '0;
  logic [E-1:0] a_exp = '0, b_exp = '0;
  logic out_valid;
  logic [F-1:0] out_frac;
  logic [E-1:0] out_exp;

  always #5 clk = ~clk;

  fp_add_pipe4 #(.FRAC_W(F), .EXP_W(E)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_frac(a_frac), .a_exp(a_exp), .b_frac(b_frac), .b_exp(b_exp),
    .out_valid(out_valid), .out_frac(out_frac), .out_exp(out_exp)
  );

  // {a_frac, a_exp, b_frac, b_exp, exp_frac, exp_exp}
  localparam logic [95:0] VEC [NV] = '{
    {24'h800000, 8'd10,  24'h800000, 8'd10,  24'h800000, 8'd11},  // R4 equal exps carry
    {24'h800000, 8'd10,  24'h800000, 8'd9,   24'hC00000, 8'd10},  // R2 B smaller
    {24'h800000, 8'd9,   24'hC00000, 8'd10,  24'h800000, 8'd11},  // R2 A smaller, R4
    {24'hFFFFFF, 8'd40,  24'h800000, 8'd16,  24'hFFFFFF, 8'd40},  // R3 t = F
    {24'h800000, 8'd40,  24'h800000, 8'd17,  24'h800001, 8'd40},  // R2 t = F-1
    {24'h900000, 8'd5,   24'hA00000, 8'd205, 24'hA00000, 8'd205}, // R3 large t
    {24'hFFFFFF, 8'd3,   24'hFFFFFF, 8'd3,   24'hFFFFFF, 8'd4},   // R4 lsb dropped
    {24'hFFFFFF, 8'd3,   24'h000001, 8'd3,   24'h800000, 8'd4},   // R4 exact carry
    {24'h000000, 8'd7,   24'h000000, 8'd7,   24'h000000, 8'd0},   // R6 zero sum
    {24'h000010, 8'd30,  24'h000010, 8'd30,  24'h800000, 8'd12},  // R5 u = 18
    {24'h100000, 8'd20,  24'h000000, 8'd20,  24'h800000, 8'd17},  // R5 u = 3
    {24'h300000, 8'd20,  24'h000000, 8'd20,  24'hC00000, 8'd18}   // R5 u = 2
  };

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input int i, input logic v);
    a_frac   = VEC[i][95:72];
    a_exp    = VEC[i][71:64];
    b_frac   = VEC[i][63:40];
    b_exp    = VEC[i][39:32];
    in_valid = v;
  endtask

  bit mon_en = 0;
  int cyc = 0, ng = 0;
  logic [F-1:0] got_frac [NV];
  logic [E-1:0] got_exp  [NV];
  int           got_cyc  [NV];

  always @(negedge clk) begin
    cyc++;
    if (mon_en && out_valid && ng < NV) begin
      got_frac[ng] = out_frac;
      got_exp[ng]  = out_exp;
      got_cyc[ng]  = cyc;
      ng++;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 out_valid in reset", 32'(out_valid), 0);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 idle out_valid", 32'(out_valid), 0);

    // table walk, back to back
    @(posedge clk) mon_en = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk) drive(i, 1'b1);
    end
    @(negedge clk) in_valid = 1'b0;
    repeat (8) @(negedge clk);
    @(posedge clk) mon_en = 0;
    check("R1 result count", 32'(ng), NV);
    for (int i = 0; i < NV && i < ng; i++) begin
      check($sformatf("R2-table frac vec%0d", i), 32'(got_frac[i]), 32'(VEC[i][31:8]));
      check($sformatf("R2-table exp vec%0d", i), 32'(got_exp[i]), 32'(VEC[i][7:0]));
      check("R1 back-to-back spacing", 32'(got_cyc[i] - got_cyc[0]), 32'(i));
    end

    // latency and bubble: valid, idle, valid
    @(negedge clk) drive(1, 1'b1);
    @(negedge clk) drive(0, 1'b0);
    @(negedge clk) drive(9, 1'b1);
    for (int k = 3; k <= 8; k++) begin
      @(negedge clk);
      if (k == 3) in_valid = 1'b0;
      check($sformatf("R1 R7 out_valid at %0d", k), 32'(out_valid),
            (k == 4 || k == 6) ? 1 : 0);
      if (k == 4) check("R1 latency data", 32'(out_frac), 32'h00C00000);
      if (k == 6) check("R5 bubble data exp", 32'(out_exp), 12);
    end

    // reset while a pair is in flight
    @(negedge clk) drive(0, 1'b1);
    @(negedge clk) begin in_valid = 1'b0; rst = 1'b1; end
    @(negedge clk) rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R7 flushed pair absent", 32'(out_valid), 0);
    end

    // swapped ports give same sum (R2)
    @(negedge clk) begin
      a_frac = 24'hC00000; a_exp = 8'd10; b_frac = 24'h800000; b_exp = 8'd9; in_valid = 1'b1;
    end
    @(negedge clk) in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 swapped valid", 32'(out_valid), 1);
    check("R2 swapped frac", 32'(out_frac), 32'h00800000);
    check("R2 swapped exp", 32'(out_exp), 11);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule